// File: doc/BRIEF.md
# Dual-Channel Serial Potentiometer Controller

This block is the digital core of a two-channel serially programmed potentiometer. A serial host shifts 16-bit frames in on a data line, clocked by a serial clock, while a select line is held low. Each frame holds a command byte followed by a data byte, most significant bit first. The block acts on a frame only when the select line returns high, and only if the number of clocks counted during that select window is a nonzero multiple of sixteen. Bits leave on a serial output one clock edge after they arrive, so several devices can be chained. The outputs are two 8-bit wiper codes and a shutdown indication for each channel.

Two active-low pins act outside the serial protocol. A preset pin forces every wiper code to mid-scale. A hardware power-down pin puts every channel into shutdown but keeps the stored codes, which take effect again when the pin is released. Software shutdown is set per channel by command. A write to a channel clears that channel's software shutdown. A rising edge on the power-down pin clears software shutdown only when a complete select pulse has happened since the pin fell.

All serial and control pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its edges are detected in the system clock domain. A synchronous power-on input stands in for the analog power-on circuit.

Top module: `pot_ctrl`

## Requirements
- R1: During and right after power-on reset, both wiper codes are 0x80, the serial output is 0, and both shutdown outputs equal the inverse of the power-down pin sampled at reset.
- R2: A 16-clock frame whose command byte has bits [5:4] = 01 loads its data byte into every channel selected by command bits [1:0] (bit 0 selects channel 0, bit 1 selects channel 1). The load happens when select rises.
- R3: When select rises after zero clocks, or after a count that is not a multiple of 16, all outputs stay unchanged.
- R4: When more than 16 clocks arrive in one window and the count is a multiple of 16, only the last 16 bits received are decoded.
- R5: Command bits [5:4] = 10 set software shutdown for every selected channel. A write command (01) clears software shutdown on the channels it loads.
- R6: Command codes 00 and 11 in bits [5:4] change neither the wiper codes nor the shutdown outputs.
- R7: While the preset pin is low and select is high, every wiper code is 0x80, and the software shutdown flags are left as they were. If select rises while the preset pin is already low, the pending frame is discarded.
- R8: While the power-down pin is low, both shutdown outputs are 1. Write commands and preset still update the stored codes, and the wiper outputs show those codes.
- R9: On a rising edge of the power-down pin, hardware shutdown ends. Software shutdown flags are cleared only if select completed a low pulse after the pin fell; otherwise they are kept.
- R10: After each falling serial-clock edge with select low, the serial output shows the bit received 16 clocks earlier. After select rises, the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous power-on reset, active high |
| sck_i | input | 1 | Serial clock (asynchronous) |
| cs_n_i | input | 1 | Frame select, active low |
| si_i | input | 1 | Serial data in |
| rs_n_i | input | 1 | Mid-scale preset, active low |
| shdn_n_i | input | 1 | Hardware power-down, active low |
| sdo_o | output | 1 | Serial data out for chaining |
| wiper_o | output | 16 | Wiper codes, channel 0 in bits [7:0] |
| off_o | output | 2 | Per-channel shutdown indication |

## Verification
Two functions can act in the same system clock cycle: a frame commit caused by select rising, and the preset forced by a low preset pin. The bench drives select high and preset low on the same system clock edge, so both pass through their synchronizers together and reach the core in the same cycle. The frame sent is a software shutdown command. The outcome is judged by seeing both wipers at 0x80 while the shutdown outputs stay clear, which shows that the preset won and the command was dropped.

// File: rtl/pot_pkg.sv
package pot_pkg;
    localparam int FRAME_W = 16;
    localparam int CODE_W  = 8;
    localparam int OP_LSB  = 12;
    localparam int SEL_LSB = 8;

    typedef enum logic [1:0] {
        OP_IDLE_A = 2'b00,
        OP_LOAD   = 2'b01,
        OP_SLEEP  = 2'b10,
        OP_IDLE_B = 2'b11
    } pot_op_e;
endpackage

// File: rtl/pot_sync.sv
module pot_sync #(
    parameter int           N    = 5,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         por,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stab;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta = din;
        st_d.stab = st_q.meta;
        st_d.prev = st_q.stab;
        if (por) begin
            st_d = {IDLE, IDLE, IDLE};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lvl  = st_q.stab;
    assign rise = st_q.stab & ~st_q.prev;
    assign fall = ~st_q.stab & st_q.prev;
endmodule

// File: rtl/pot_spi_rx.sv
module pot_spi_rx #(
    parameter int FW = pot_pkg::FRAME_W,
    localparam int CW = $clog2(FW)
) (
    input  logic          clk,
    input  logic          por,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          cs_lvl,
    input  logic          cs_rise,
    input  logic          cs_fall,
    input  logic          si,
    output logic          frame_valid,
    output logic [FW-1:0] frame,
    output logic          sdo
);
    typedef struct packed {
        logic [FW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          any;
        logic          so;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [CW-1:0] cnt_base;

    always_comb begin
        rx_d        = rx_q;
        frame_valid = 1'b0;
        cnt_base    = cs_fall ? '0 : rx_q.cnt;
        if (cs_fall) begin
            rx_d.cnt = '0;
            rx_d.any = 1'b0;
        end
        if (!cs_lvl && sck_rise) begin
            rx_d.sh  = {rx_q.sh[FW-2:0], si};
            rx_d.cnt = (cnt_base == CW'(FW - 1)) ? '0 : cnt_base + 1'b1;
            rx_d.any = 1'b1;
        end
        if (!cs_lvl && sck_fall) begin
            rx_d.so = rx_q.sh[FW-1];
        end
        if (cs_rise) begin
            rx_d.so     = 1'b0;
            frame_valid = rx_q.any && (rx_q.cnt == '0);
        end
        if (por) begin
            rx_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        rx_q <= rx_d;
    end

    assign frame = rx_q.sh;
    assign sdo   = rx_q.so;

    AST_SDO_CLEARS: assert property (@(posedge clk) disable iff (por)
        cs_rise |=> (sdo == 1'b0)); // R10
endmodule

// File: rtl/pot_bank.sv
module pot_bank
    import pot_pkg::*;
#(
    parameter int          NCH = 2,
    parameter int          DW  = CODE_W,
    parameter int          FW  = FRAME_W,
    parameter logic [DW-1:0] MID = DW'(1) << (DW - 1)
) (
    input  logic              clk,
    input  logic              por,
    input  logic              shdn_pin_n,
    input  logic              cmd_valid,
    input  logic [FW-1:0]     frame,
    input  logic              rs_lvl,
    input  logic              cs_lvl,
    input  logic              cs_rise,
    input  logic              shdn_rise,
    input  logic              shdn_fall,
    output logic [NCH*DW-1:0] wiper_o,
    output logic [NCH-1:0]    off_o
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] wip;
        logic [NCH-1:0]         sw;
        logic                   hw;
        logic                   pulsed;
    } bank_t;

    bank_t bk_d, bk_q;
    pot_op_e        op;
    logic [NCH-1:0] sel;
    logic [DW-1:0]  data;
    logic           preset;
    logic [FW-1:0]  unused_frame;

    assign op           = pot_op_e'(frame[OP_LSB+1:OP_LSB]);
    assign sel          = frame[SEL_LSB+NCH-1:SEL_LSB];
    assign data         = frame[DW-1:0];
    assign preset       = !rs_lvl && cs_lvl;
    assign unused_frame = frame;

    always_comb begin
        bk_d = bk_q;
        if (cs_rise) begin
            bk_d.pulsed = 1'b1;
        end
        if (cmd_valid && !preset) begin
            case (op)
                OP_LOAD: begin
                    for (int c = 0; c < NCH; c++) begin
                        if (sel[c]) begin
                            bk_d.wip[c] = data;
                            bk_d.sw[c]  = 1'b0;
                        end
                    end
                end
                OP_SLEEP: bk_d.sw = bk_q.sw | sel;
                default:  ;
            endcase
        end
        if (preset) begin
            for (int c = 0; c < NCH; c++) begin
                bk_d.wip[c] = MID;
            end
        end
        if (shdn_fall) begin
            bk_d.hw     = 1'b1;
            bk_d.pulsed = 1'b0;
        end
        if (shdn_rise) begin
            bk_d.hw = 1'b0;
            if (bk_q.pulsed) begin
                bk_d.sw = '0;
            end
            bk_d.pulsed = 1'b0;
        end
        if (por) begin
            for (int c = 0; c < NCH; c++) begin
                bk_d.wip[c] = MID;
            end
            bk_d.sw     = '0;
            bk_d.hw     = !shdn_pin_n;
            bk_d.pulsed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        bk_q <= bk_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign wiper_o[g*DW +: DW] = bk_q.wip[g];
        assign off_o[g]            = bk_q.sw[g] | bk_q.hw;
    end

    AST_PRESET_MID: assert property (@(posedge clk) disable iff (por)
        preset |=> (wiper_o == {NCH{MID}})); // R7
    AST_LOAD_CH0: assert property (@(posedge clk) disable iff (por)
        (cmd_valid && op == OP_LOAD && sel[0] && rs_lvl)
        |=> (wiper_o[DW-1:0] == $past(data))); // R2
    AST_CODES_HOLD: assert property (@(posedge clk) disable iff (por)
        (!cmd_valid && !preset) |=> $stable(wiper_o)); // R3
    AST_PWRDN_ALL_OFF: assert property (@(posedge clk) disable iff (por)
        shdn_fall |=> (&off_o)); // R8
endmodule

// File: rtl/pot_ctrl.sv
module pot_ctrl
    import pot_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = CODE_W
) (
    input  logic              clk,
    input  logic              por,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              si_i,
    input  logic              rs_n_i,
    input  logic              shdn_n_i,
    output logic              sdo_o,
    output logic [NCH*DW-1:0] wiper_o,
    output logic [NCH-1:0]    off_o
);
    localparam int PIN_N  = 5;
    localparam int P_SCK  = 0;
    localparam int P_CS   = 1;
    localparam int P_SI   = 2;
    localparam int P_RS   = 3;
    localparam int P_SHDN = 4;
    localparam logic [PIN_N-1:0] PIN_IDLE = 5'b11010;

    logic [PIN_N-1:0]   pins, lvl, rise, fall;
    logic               cmd_valid;
    logic [FRAME_W-1:0] frame;
    logic [5:0]         unused_edges;

    assign pins = {shdn_n_i, rs_n_i, si_i, cs_n_i, sck_i};
    assign unused_edges = {lvl[P_SCK], rise[P_SI], fall[P_SI],
                           rise[P_RS], fall[P_RS], lvl[P_SHDN]};

    pot_sync #(.N(PIN_N), .IDLE(PIN_IDLE)) u_sync (
        .clk  (clk),
        .por  (por),
        .din  (pins),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    pot_spi_rx #(.FW(FRAME_W)) u_rx (
        .clk         (clk),
        .por         (por),
        .sck_rise    (rise[P_SCK]),
        .sck_fall    (fall[P_SCK]),
        .cs_lvl      (lvl[P_CS]),
        .cs_rise     (rise[P_CS]),
        .cs_fall     (fall[P_CS]),
        .si          (lvl[P_SI]),
        .frame_valid (cmd_valid),
        .frame       (frame),
        .sdo         (sdo_o)
    );

    pot_bank #(.NCH(NCH), .DW(DW), .FW(FRAME_W)) u_bank (
        .clk        (clk),
        .por        (por),
        .shdn_pin_n (shdn_n_i),
        .cmd_valid  (cmd_valid),
        .frame      (frame),
        .rs_lvl     (lvl[P_RS]),
        .cs_lvl     (lvl[P_CS]),
        .cs_rise    (rise[P_CS]),
        .shdn_rise  (rise[P_SHDN]),
        .shdn_fall  (fall[P_SHDN]),
        .wiper_o    (wiper_o),
        .off_o      (off_o)
    );

    AST_SDO_ZERO_IDLE: assert property (@(posedge clk) disable iff (por)
        (lvl[P_CS] && $past(lvl[P_CS])) |-> (sdo_o == 1'b0)); // R10
endmodule

// File: tb/sim_pot_ctrl.sv
module sim_pot_ctrl;
    logic        clk = 1'b0;
    logic        por, sck, cs_n, si, rs_n, shdn_n;
    logic        sdo;
    logic [15:0] wip;
    logic [1:0]  off;

    always #2 clk = ~clk;

    pot_ctrl u0 (
        .clk(clk), .por(por), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .rs_n_i(rs_n), .shdn_n_i(shdn_n), .sdo_o(sdo), .wiper_o(wip), .off_o(off)
    );

    typedef struct {
        string       tag;
        bit          is_so;
        logic [15:0] wip;
        logic [1:0]  off;
        logic        so;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] mw [2];
    logic [1:0] msw;
    logic       mhw, mpul;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_state(string tag);
        exp_t e;
        e.tag = tag; e.is_so = 1'b0; e.wip = {mw[1], mw[0]};
        e.off = msw | {2{mhw}}; e.so = 1'b0;
        sbq.push_back(e);
    endtask

    task automatic push_so(string tag, logic v);
        exp_t e;
        e.tag = tag; e.is_so = 1'b1; e.wip = '0; e.off = '0; e.so = v;
        sbq.push_back(e);
    endtask

    // monitor: pops expectations and compares away from the clock edge
    initial begin
        forever begin
            wait (sbq.size() > 0);
            #1;
            begin
                exp_t e;
                e = sbq.pop_front();
                n_chk++;
                if (e.is_so) begin
                    if (sdo !== e.so) begin
                        n_fail++;
                        $display("FAIL %s: sdo=%b expected %b", e.tag, sdo, e.so);
                    end
                end else if (wip !== e.wip || off !== e.off) begin
                    n_fail++;
                    $display("FAIL %s: wiper=%h off=%b expected wiper=%h off=%b",
                             e.tag, wip, off, e.wip, e.off);
                end
            end
        end
    end

    function automatic void apply(logic [15:0] w);
        if (w[13:12] == 2'b01) begin
            for (int c = 0; c < 2; c++) begin
                if (w[8+c]) begin
                    mw[c]  = w[7:0];
                    msw[c] = 1'b0;
                end
            end
        end else if (w[13:12] == 2'b10) begin
            msw = msw | w[9:8];
        end
    endfunction

    task automatic xfer(logic [31:0] bits, int n, string tag, bit chk_so, bit rs_at_rise);
        cs_n = 1'b0;
        tick(4);
        for (int k = 1; k <= n; k++) begin
            si = bits[n-k];
            tick(4);
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
            tick(4);
            if (chk_so && k >= 16) push_so("R10 chained bit", bits[n-k+15]);
        end
        cs_n = 1'b0;
        cs_n = 1'b1;
        if (rs_at_rise) rs_n = 1'b0;
        tick(6);
        mpul = 1'b1;
        if (rs_at_rise) begin
            mw[0] = 8'h80; mw[1] = 8'h80;
        end else if (n > 0 && n % 16 == 0) begin
            apply(bits[15:0]);
        end
        push_state(tag);
        push_so("R10 sdo low after select", 1'b0);
        if (rs_at_rise) begin
            rs_n = 1'b1;
            tick(4);
        end
    endtask

    task automatic set_shdn(logic v, string tag);
        shdn_n = v;
        tick(6);
        if (!v) begin
            mhw = 1'b1; mpul = 1'b0;
        end else begin
            mhw = 1'b0;
            if (mpul) msw = '0;
            mpul = 1'b0;
        end
        push_state(tag);
    endtask

    task automatic pulse_rs(string tag);
        rs_n = 1'b0;
        tick(6);
        mw[0] = 8'h80; mw[1] = 8'h80;
        push_state(tag);
        rs_n = 1'b1;
        tick(4);
    endtask

    task automatic power_on(logic shdn_level);
        por = 1'b1; sck = 1'b0; cs_n = 1'b1; si = 1'b0; rs_n = 1'b1;
        shdn_n = shdn_level;
        tick(5);
        por = 1'b0;
        mw[0] = 8'h80; mw[1] = 8'h80; msw = '0; mhw = !shdn_level; mpul = 1'b0;
        tick(1);
        push_state("R1 power-on state");
        push_so("R1 sdo at power-on", 1'b0);
        tick(6);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        power_on(1'b1);
        // R2 writes
        xfer(32'h0000_1111, 16, "R2 write ch0", 1'b0, 1'b0);
        xfer(32'h0000_13A5, 16, "R2 write both", 1'b0, 1'b0);
        // R3 incomplete windows
        xfer(32'h0000_013F, 12, "R3 twelve clocks", 1'b0, 1'b0);
        xfer(32'h0, 0, "R3 zero clocks", 1'b0, 1'b0);
        xfer(32'h0001_1333, 17, "R3 seventeen clocks", 1'b0, 1'b0);
        // R4 and R10: 32 clocks, chained output
        xfer(32'h1234_1242, 32, "R4 last frame wins", 1'b1, 1'b0);
        // R6 no-op codes
        xfer(32'h0000_0333, 16, "R6 code 00", 1'b0, 1'b0);
        xfer(32'h0000_3333, 16, "R6 code 11", 1'b0, 1'b0);
        // R5 software shutdown
        xfer(32'h0000_2200, 16, "R5 sleep ch1", 1'b0, 1'b0);
        xfer(32'h0000_1277, 16, "R5 write wakes ch1", 1'b0, 1'b0);
        xfer(32'h0000_2300, 16, "R5 sleep both", 1'b0, 1'b0);
        xfer(32'h0000_1155, 16, "R5 write wakes ch0", 1'b0, 1'b0);
        xfer(32'h0000_2300, 16, "R5 sleep both again", 1'b0, 1'b0);
        // R8 and R9 hardware power-down
        set_shdn(1'b0, "R8 power-down holds codes");
        set_shdn(1'b1, "R9 rise without select pulse keeps sleep");
        set_shdn(1'b0, "R8 power-down again");
        xfer(32'h0000_1399, 16, "R8 write during power-down", 1'b0, 1'b0);
        pulse_rs("R7 preset during power-down");
        xfer(32'h0000_2300, 16, "R8 sleep during power-down", 1'b0, 1'b0);
        set_shdn(1'b1, "R9 rise after select pulse clears sleep");
        // R7 preset and commit in the same cycle
        xfer(32'h0000_13C3, 16, "R2 write before preset", 1'b0, 1'b0);
        xfer(32'h0000_2300, 16, "R7 preset beats sleep commit", 1'b0, 1'b1);
        pulse_rs("R7 preset pulse");
        // R1 power-on with power-down pin low
        power_on(1'b0);
        xfer(32'h0, 0, "R9 select pulse in power-down", 1'b0, 1'b0);
        set_shdn(1'b1, "R9 leave power-down");
        wait (sbq.size() == 0);
        #3;
        finish_run();
    end
endmodule